// File: doc/BRIEF.md
# SDRAM Mode Register and Read Latency Pipeline

This block sits inside an SDRAM controller and keeps the settings the controller last programmed into the memory's mode register. A load strobe presents a 10-bit mode word. The block checks the word for legality. A legal word updates the decoded burst length, burst ordering, CAS latency and write-burst flag. An illegal word leaves all of them untouched and raises an error flag.

The block also times the return of read data. Each READ the controller issues is pulsed on `rd_issue` in the clock cycle the memory registers it. The block then produces two signals:
- `bus_drive` rises one cycle ahead of the first beat, which is when the memory starts driving the data bus.
- `capture` marks every cycle whose closing edge should latch a data beat. It covers the whole burst, or stops early on a terminate request.

Mode word layout:

| Bits | Field |
|------|-------|
| [2:0] | Burst length code |
| [3] | Burst type |
| [6:4] | Latency code |
| [8:7] | Operating mode |
| [9] | Write-burst select |

Top module: `sdram_mode_rdpipe`

## Requirements
- R1: After reset the block reports burst length 1, sequential order (`burst_ilv`=0), CAS latency 3, burst writes (`wr_single`=0), `mode_err`=0, and `capture` and `bus_drive` low.
- R2: Latency code bits [6:4] of 010 give latency 2 and 011 give latency 3. Any other latency code is reserved: the load sets `mode_err` and changes no decoded field.
- R3: Operating-mode bits [8:7] must be 00. The values 01, 10 and 11 make the load set `mode_err` and change no decoded field.
- R4: Burst length codes in bits [2:0] decode as follows:
  - 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8.
  - 111 gives a full page of PAGE_LEN (default 256) beats, but only with sequential order.
  - Codes 100, 101 and 110, and 111 together with interleaved order, are reserved: they set `mode_err` and change no field.
- R5: On a legal load, bit [3] sets `burst_ilv` (0 sequential, 1 interleaved) and bit [9] sets `wr_single` (0 writes use the burst length, 1 writes are single-location).
- R6: Decoded fields change only at a clock edge where `mode_load` is high. `mode_err` is rewritten on every load: 1 if the word was rejected, 0 if it was accepted.
- R7: For a READ sampled on `rd_issue` at edge n with latency m, `capture` is high in the cycle that ends at edge n+m. That cycle is the first valid beat.
- R8: `bus_drive` rises one cycle before `capture` rises, is high in every cycle where `capture` is high, and falls together with `capture`.
- R9: With no terminate request and no further READ, `capture` stays high for exactly burst-length consecutive cycles.
- R10: A `rd_stop` sampled high at an edge makes `capture` and `bus_drive` low after that edge, unless a new burst starts at that same edge.
- R11: A READ whose first beat arrives while a burst is still running restarts the beat count. READs on consecutive cycles, or spaced closer than the burst length, give one continuous `capture` window with no gap cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_load | input | 1 | Load strobe for the mode word |
| mode_val | input | 10 | Mode word |
| rd_issue | input | 1 | READ registered by the memory this cycle |
| rd_stop | input | 1 | Terminate the running read burst |
| burst_len | output | LEN_W (9) | Decoded burst length in beats |
| burst_ilv | output | 1 | 1 = interleaved burst order |
| cas_lat | output | 2 | CAS latency, 2 or 3 |
| wr_single | output | 1 | 1 = writes are single-location |
| mode_err | output | 1 | Last load was rejected |
| bus_drive | output | 1 | Memory is driving the data bus |
| capture | output | 1 | Latch a data beat at the end of this cycle |

## Verification
The bench targets the following corner cases, and what a faulty design would show for each:

| Corner case | Symptom of a faulty design |
|-------------|----------------------------|
| Exact cycle of the first beat at both latencies | Off-by-one latency tap: the capture window shifts by a cycle. |
| One-cycle lead of `bus_drive` | A missing lead shows `bus_drive` and `capture` rising together. |
| Each class of reserved word: latency code, operating mode, length code, full page with interleaving | A design that accepts any of them alters the decoded fields it should have held. |
| Full-page burst length, with burst-length and terminate checks | A wrong full-page count or a missed terminate lengthens or shortens the window. |
| Reads spaced one or two cycles apart | A design that does not restart the beat count leaves a gap in the capture window, or ends it early. |

// File: rtl/sdram_mode_pkg.sv
package sdram_mode_pkg;

  localparam int MODE_W = 10;

  typedef struct packed {
    logic       wr_single;
    logic [1:0] opmode;
    logic [2:0] lat_code;
    logic       ilv;
    logic [2:0] len_code;
  } mode_word_t;

  function automatic logic len_code_ok(input logic [2:0] code, input logic ilv);
    return (code <= 3'd3) || (code == 3'd7 && !ilv);
  endfunction

  function automatic logic lat_code_ok(input logic [2:0] code);
    return (code == 3'd2) || (code == 3'd3);
  endfunction

endpackage

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
  import sdram_mode_pkg::*;
#(
  parameter int PAGE_LEN = 256,
  parameter int LEN_W    = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_load,
  input  logic [MODE_W-1:0] mode_val,
  output logic [LEN_W-1:0]  burst_len,
  output logic              burst_ilv,
  output logic [1:0]        cas_lat,
  output logic              wr_single,
  output logic              mode_err
);

  mode_word_t           word;
  logic                 legal;
  logic [LEN_W-1:0]     len_dec;

  assign word  = mode_word_t'(mode_val);
  assign legal = (word.opmode == 2'b00) && lat_code_ok(word.lat_code)
               && len_code_ok(word.len_code, word.ilv);

  always_comb begin
    if (word.len_code == 3'd7) len_dec = LEN_W'(PAGE_LEN);
    else                       len_dec = LEN_W'(1) << word.len_code[1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_len <= LEN_W'(1);
      burst_ilv <= 1'b0;
      cas_lat   <= 2'd3;
      wr_single <= 1'b0;
      mode_err  <= 1'b0;
    end else if (mode_load) begin
      mode_err <= !legal;
      if (legal) begin
        burst_len <= len_dec;
        burst_ilv <= word.ilv;
        cas_lat   <= word.lat_code[1:0];
        wr_single <= word.wr_single;
      end
    end
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !mode_load |=> $stable({burst_len, burst_ilv, cas_lat, wr_single, mode_err}));

  assert_reject_opmode_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_load && mode_val[8:7] != 2'b00) |=>
      (mode_err && $stable({burst_len, burst_ilv, cas_lat, wr_single})));

  assert_reject_lat_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_load && mode_val[6:4] != 3'd2 && mode_val[6:4] != 3'd3) |=>
      (mode_err && $stable(cas_lat)));

  assert_cas_range_R2: assert property (@(posedge clk) disable iff (rst)
    (cas_lat == 2'd2) || (cas_lat == 2'd3));

endmodule

// File: rtl/sdram_read_pipe.sv
module sdram_read_pipe #(
  parameter int MAX_CL = 3,
  parameter int LEN_W  = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_issue,
  input  logic             rd_stop,
  input  logic [1:0]       cas_lat,
  input  logic [LEN_W-1:0] burst_len,
  output logic             capture,
  output logic             bus_drive
);

  localparam int SH_W = MAX_CL - 1;

  logic [SH_W-1:0]   shreg;
  logic [MAX_CL-1:0] taps;
  logic              start_drv, start_cap;
  logic              cap_d, drv_d;
  logic [LEN_W-1:0]  rem, rem_d;

  assign taps      = {shreg, rd_issue};
  assign start_drv = taps[cas_lat - 2'd2];
  assign start_cap = taps[cas_lat - 2'd1];

  always_comb begin
    cap_d = 1'b0;
    rem_d = rem;
    if (start_cap) begin
      cap_d = 1'b1;
      rem_d = burst_len - LEN_W'(1);
    end else if (rd_stop) begin
      rem_d = '0;
    end else if (rem != '0) begin
      cap_d = 1'b1;
      rem_d = rem - LEN_W'(1);
    end
    drv_d = cap_d | start_drv;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      rem       <= '0;
      capture   <= 1'b0;
      bus_drive <= 1'b0;
    end else begin
      shreg     <= {shreg[SH_W-2:0], rd_issue};
      rem       <= rem_d;
      capture   <= cap_d;
      bus_drive <= drv_d;
    end
  end

  logic [LEN_W-1:0] beat_cnt;
  always_ff @(posedge clk) begin
    if (rst)             beat_cnt <= '0;
    else if (start_cap)  beat_cnt <= LEN_W'(1);
    else if (capture && beat_cnt != '1) beat_cnt <= beat_cnt + LEN_W'(1);
  end

  assert_drive_leads_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(capture) |-> $past(bus_drive));

  assert_cap_in_drive_R8: assert property (@(posedge clk) disable iff (rst)
    capture |-> bus_drive);

  assert_burst_len_R9: assert property (@(posedge clk) disable iff (rst)
    capture |-> (beat_cnt != '0 && beat_cnt <= burst_len));

endmodule

// File: rtl/sdram_mode_rdpipe.sv
module sdram_mode_rdpipe
  import sdram_mode_pkg::*;
#(
  parameter int PAGE_LEN = 256,
  parameter int MAX_CL   = 3,
  parameter int LEN_W    = $clog2(PAGE_LEN) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_load,
  input  logic [MODE_W-1:0] mode_val,
  input  logic              rd_issue,
  input  logic              rd_stop,
  output logic [LEN_W-1:0]  burst_len,
  output logic              burst_ilv,
  output logic [1:0]        cas_lat,
  output logic              wr_single,
  output logic              mode_err,
  output logic              bus_drive,
  output logic              capture
);

  sdram_mode_reg #(.PAGE_LEN(PAGE_LEN), .LEN_W(LEN_W)) u_mode (
    .clk(clk), .rst(rst), .mode_load(mode_load), .mode_val(mode_val),
    .burst_len(burst_len), .burst_ilv(burst_ilv), .cas_lat(cas_lat),
    .wr_single(wr_single), .mode_err(mode_err)
  );

  sdram_read_pipe #(.MAX_CL(MAX_CL), .LEN_W(LEN_W)) u_pipe (
    .clk(clk), .rst(rst), .rd_issue(rd_issue), .rd_stop(rd_stop),
    .cas_lat(cas_lat), .burst_len(burst_len),
    .capture(capture), .bus_drive(bus_drive)
  );

endmodule

// File: tb/sim_sdram_mode_rdpipe.sv
module sim_sdram_mode_rdpipe;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_load = 1'b0;
  logic [9:0] mode_val = '0;
  logic       rd_issue = 1'b0;
  logic       rd_stop = 1'b0;
  logic [8:0] burst_len;
  logic       burst_ilv, wr_single, mode_err, bus_drive, capture;
  logic [1:0] cas_lat;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  sdram_mode_rdpipe u0 (
    .clk(clk), .rst(rst), .mode_load(mode_load), .mode_val(mode_val),
    .rd_issue(rd_issue), .rd_stop(rd_stop), .burst_len(burst_len),
    .burst_ilv(burst_ilv), .cas_lat(cas_lat), .wr_single(wr_single),
    .mode_err(mode_err), .bus_drive(bus_drive), .capture(capture)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [9:0] mw(input int opm, input int wr, input int lat,
                                    input int ilv, input int len);
    return {wr[0], opm[1:0], lat[2:0], ilv[0], len[2:0]};
  endfunction

  task automatic load_mode(input logic [9:0] v);
    @(negedge clk); mode_load = 1'b1; mode_val = v;
    @(negedge clk); mode_load = 1'b0; mode_val = ~v;
  endtask

  task automatic check_fields(input string req, input int bl, input int ilv,
                              input int cl, input int wr, input int err);
    check({req, " burst_len"}, int'(burst_len), bl);
    check({req, " burst_ilv"}, int'(burst_ilv), ilv);
    check({req, " cas_lat"},   int'(cas_lat),   cl);
    check({req, " wr_single"}, int'(wr_single), wr);
    check({req, " mode_err"},  int'(mode_err),  err);
  endtask

  // R7 R8 R9: single read, window compared cycle by cycle
  task automatic run_read(input string req, input int cl, input int bl);
    @(negedge clk); rd_issue = 1'b1;
    for (int k = 1; k <= cl + bl + 1; k++) begin
      @(negedge clk); rd_issue = 1'b0;
      check({req, " capture"},   int'(capture),   int'(k >= cl && k < cl + bl));
      check({req, " bus_drive"}, int'(bus_drive), int'(k >= cl - 1 && k < cl + bl));
    end
  endtask

  task automatic t_reset;
    check_fields("R1", 1, 0, 3, 0, 0);
    check("R1 capture", int'(capture), 0);
    check("R1 bus_drive", int'(bus_drive), 0);
  endtask

  task automatic t_legal_loads;
    load_mode(mw(0, 0, 2, 0, 2));
    check_fields("R2 R4 lat2 len4", 4, 0, 2, 0, 0);
    run_read("R7 R9 cl2 bl4", 2, 4);
    load_mode(mw(0, 1, 3, 1, 3));
    check_fields("R5 lat3 len8 ilv wr1", 8, 1, 3, 1, 0);
    run_read("R7 R8 cl3 bl8", 3, 8);
    load_mode(mw(0, 0, 2, 0, 1));
    check_fields("R4 len2", 2, 0, 2, 0, 0);
    run_read("R9 cl2 bl2", 2, 2);
  endtask

  task automatic t_reserved;
    load_mode(mw(0, 1, 3, 1, 3));
    load_mode(mw(0, 0, 4, 0, 0));
    check_fields("R2 reserved lat", 8, 1, 3, 1, 1);
    load_mode(mw(0, 0, 1, 0, 0));
    check_fields("R2 reserved lat1", 8, 1, 3, 1, 1);
    load_mode(mw(1, 0, 2, 0, 0));
    check_fields("R3 opmode01", 8, 1, 3, 1, 1);
    load_mode(mw(2, 0, 2, 0, 0));
    check_fields("R3 opmode10", 8, 1, 3, 1, 1);
    load_mode(mw(0, 0, 2, 0, 5));
    check_fields("R4 len code 101", 8, 1, 3, 1, 1);
    load_mode(mw(0, 0, 2, 1, 7));
    check_fields("R4 full page ilv", 8, 1, 3, 1, 1);
    load_mode(mw(0, 0, 2, 0, 0));
    check_fields("R6 err cleared len1", 1, 0, 2, 0, 0);
  endtask

  task automatic t_hold;
    @(negedge clk); mode_val = mw(0, 1, 3, 1, 3);
    repeat (3) @(negedge clk);
    check_fields("R6 no load", 1, 0, 2, 0, 0);
  endtask

  task automatic t_full_page;
    int n = 0;
    load_mode(mw(0, 0, 2, 0, 7));
    check_fields("R4 full page", 256, 0, 2, 0, 0);
    @(negedge clk); rd_issue = 1'b1;
    for (int k = 1; k <= 270; k++) begin
      @(negedge clk); rd_issue = 1'b0;
      if (capture) n++;
    end
    check("R9 full page beats", n, 256);
  endtask

  task automatic t_stop;
    load_mode(mw(0, 0, 2, 0, 3));
    @(negedge clk); rd_issue = 1'b1;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk); rd_issue = 1'b0;
      check("R10 capture", int'(capture), int'(k >= 2 && k <= 4));
      check("R10 bus_drive", int'(bus_drive), int'(k >= 1 && k <= 4));
      rd_stop = (k == 4);
    end
    rd_stop = 1'b0;
  endtask

  task automatic t_back_to_back;
    load_mode(mw(0, 0, 3, 0, 0));
    @(negedge clk); rd_issue = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk); rd_issue = (k < 3);
      check("R11 bl1 capture", int'(capture), int'(k >= 3 && k <= 5));
      check("R11 bl1 bus_drive", int'(bus_drive), int'(k >= 2 && k <= 5));
    end
    load_mode(mw(0, 0, 2, 0, 2));
    @(negedge clk); rd_issue = 1'b1;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk); rd_issue = (k == 2);
      check("R11 restart capture", int'(capture), int'(k >= 2 && k <= 7));
      check("R11 restart bus_drive", int'(bus_drive), int'(k >= 1 && k <= 7));
    end
    rd_issue = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_legal_loads();
    t_reserved();
    t_hold();
    t_full_page();
    t_stop();
    t_back_to_back();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule